// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh and Start-Up Manager

This block keeps an asynchronous pseudo-static RAM alive and ready to use. After reset it holds the memory's chip enable inactive for a long settling wait. It then issues a fixed number of dummy chip-enable cycles. Once that is done it reports that the memory is usable and hands the memory pins to an access sequencer. From then on a free-running interval timer paces refreshes so that every row is visited within the retention period.

For each refresh the block raises a bus request and waits for the grant. It then drives the refresh strobe or the chip enable itself, and gives the pins back when the refresh ends. Two refresh styles are selected by a plain control input. In strobe refresh the refresh pin is pulsed low. In row refresh the chip enable is pulsed with a row address taken from an internal counter.

A low-power request puts the memory into self refresh. The block asks for the bus, then holds the refresh pin low with chip enable inactive for as long as the request stays high, and never for less than a minimum. After the pin returns high it waits out an exit delay before releasing the bus. Refresh pacing is suspended while the memory refreshes itself, and restarts from zero on release. All pins are control signals with no data flow, so there is no valid/ready interface. bus_req and bus_gnt form a plain level handshake: the sequencer must hold bus_gnt high until bus_req falls.

Top module: `psr_refresh_mgr`

## Requirements
- R1: While reset is asserted, bus_req=1, ce_n=1, rfsh_n=1, init_done=0, self_active=0 and overrun=0.
- R2: After reset release, ce_n stays high for INIT_WAIT_CYC cycles. Exactly DUMMY_CNT chip-enable pulses follow, each CE_LOW_CYC cycles low and CE_PRE_CYC cycles high. init_done rises, and bus_req falls, in the cycle the last high phase ends. No grant is needed during this start-up phase.
- R3: The refresh timer starts when init_done rises. A refresh bus_req rises exactly REF_INTERVAL_CYC cycles later and every REF_INTERVAL_CYC cycles after that, and the pacing is not shifted by the refreshes themselves.
- R4: With ref_style=0 (strobe refresh), the first grant cycle starts a lead phase in which ce_n stays high. rfsh_n falls CE_LEAD_CYC cycles after that cycle and stays low for RF_LOW_CYC cycles. bus_req falls max(RF_PRE_CYC, CE_HOLD_CYC, AUTO_CYCLE_CYC-RF_LOW_CYC) cycles after rfsh_n rises, and ce_n stays high throughout.
- R5: With ref_style=1 (row refresh), ce_n falls CE_LEAD_CYC cycles after the grant and stays low for CE_LOW_CYC cycles, while row_addr shows the row counter and rfsh_n stays high. bus_req falls CE_PRE_CYC cycles after ce_n rises. The counter then steps by one, modulo 2^ROW_BITS, starting from 0.
- R6: After start-up, ce_n and rfsh_n are driven low only while bus_gnt is high. Both are never low together.
- R7: If a refresh is still waiting for its grant when the next interval expires, overrun is set. It stays set until reset.
- R8: A high lp_req seen while idle raises bus_req. After the grant and the lead phase, rfsh_n is held low with ce_n high, and self_active is 1. rfsh_n stays low for max(SELF_MIN_CYC, the number of cycles until lp_req is seen low).
- R9: After self refresh, bus_req falls SELF_EXIT_CYC cycles after rfsh_n rises. Refresh pacing is suspended during self refresh, and the next refresh request comes REF_INTERVAL_CYC cycles after the release.
- R10: lp_req is acted on only when idle, and a due refresh takes precedence over it. A refresh already requested completes its strobe before self refresh begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_req | input | 1 | Low-power request; high asks for self refresh |
| ref_style | input | 1 | 0 = strobe refresh, 1 = row refresh through chip enable |
| bus_gnt | input | 1 | Grant from the access sequencer, held until bus_req falls |
| bus_req | output | 1 | Request for, and ownership of, the memory pins |
| ce_n | output | 1 | Active-low chip enable while the block owns the pins |
| rfsh_n | output | 1 | Active-low refresh strobe |
| row_addr | output | ROW_BITS | Row address for row refresh |
| init_done | output | 1 | Start-up wait and dummy cycles complete |
| self_active | output | 1 | Memory is in self refresh |
| overrun | output | 1 | Sticky missed-refresh flag |

## Verification
Every result has a fixed latency counted in clock edges. The first dummy pulse falls INIT_WAIT_CYC edges after reset, and init_done rises 160 edges after that with the defaults. A pin falls CE_LEAD_CYC edges after the first edge that sees the grant. The release comes AUTO_TAIL, CE_PRE_CYC or SELF_EXIT_CYC edges after the strobe rises, and a refresh request comes a whole number of REF_INTERVAL_CYC edges after the timer start. The bench counts edges since reset and samples one nanosecond after each rising edge. A driver queues each expected pulse with its width and row, and a monitor measures every observed pulse in edges and pops the queue to compare. Lead, release and request cycles are compared against the counted edges, and queue order shows that a pending refresh beats a low-power request.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_DUM_LO,
    ST_DUM_HI,
    ST_IDLE,
    ST_REQ,
    ST_LEAD,
    ST_AR_LOW,
    ST_AR_TAIL,
    ST_CR_LOW,
    ST_CR_HI,
    ST_SR_LOW,
    ST_SR_EXIT
  } psr_state_e;

  typedef enum logic {
    STYLE_STROBE = 1'b0,
    STYLE_ROW    = 1'b1
  } psr_style_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psr_tick_timer.sv
`timescale 1ns/1ps
module psr_tick_timer #(
  parameter int INTERVAL_CYC = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      count <= '0;
    end else if (count == LAST) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  assign tick = run && (count == LAST);
endmodule

// File: rtl/psr_row_ctr.sv
`timescale 1ns/1ps
module psr_row_ctr #(
  parameter int ROW_BITS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  output logic [ROW_BITS-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '0;
    end else if (inc) begin
      row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/psr_fsm.sv
`timescale 1ns/1ps
module psr_fsm
  import psr_pkg::*;
#(
  parameter int INIT_WAIT_CYC  = 20000,
  parameter int DUMMY_CNT      = 8,
  parameter int CE_LOW_CYC     = 12,
  parameter int CE_PRE_CYC     = 8,
  parameter int RF_LOW_CYC     = 6,
  parameter int RF_PRE_CYC     = 6,
  parameter int AUTO_CYCLE_CYC = 20,
  parameter int CE_LEAD_CYC    = 6,
  parameter int CE_HOLD_CYC    = 4,
  parameter int SELF_MIN_CYC   = 1600,
  parameter int SELF_EXIT_CYC  = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_req,
  input  logic       ref_style,
  input  logic       bus_gnt,
  input  logic       tick,
  output psr_state_e state,
  output logic       row_inc,
  output logic       timer_run,
  output logic       overrun
);
  localparam int AUTO_TAIL = max3(RF_PRE_CYC, CE_HOLD_CYC, AUTO_CYCLE_CYC - RF_LOW_CYC);
  localparam int SPAN = INIT_WAIT_CYC + SELF_MIN_CYC + SELF_EXIT_CYC + CE_LOW_CYC
                      + CE_PRE_CYC + RF_LOW_CYC + AUTO_TAIL + CE_LEAD_CYC;
  localparam int CNT_W = $clog2(SPAN + 1);
  localparam int DC_W  = $clog2(DUMMY_CNT + 1);

  localparam logic [CNT_W-1:0] L_INIT  = CNT_W'(INIT_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] L_CELO  = CNT_W'(CE_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] L_CEPRE = CNT_W'(CE_PRE_CYC - 1);
  localparam logic [CNT_W-1:0] L_LEAD  = CNT_W'(CE_LEAD_CYC - 1);
  localparam logic [CNT_W-1:0] L_ARLO  = CNT_W'(RF_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] L_TAIL  = CNT_W'(AUTO_TAIL - 1);
  localparam logic [CNT_W-1:0] L_SMIN  = CNT_W'(SELF_MIN_CYC - 1);
  localparam logic [CNT_W-1:0] L_SEXIT = CNT_W'(SELF_EXIT_CYC - 1);
  localparam logic [DC_W-1:0]  D_LAST  = DC_W'(DUMMY_CNT - 1);

  psr_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [DC_W-1:0]  dcnt;
  logic             go_self;
  logic             use_row;
  logic             pending;
  logic             done;
  logic             start;

  assign done  = (cnt == '0);
  assign start = (st == ST_REQ) && bus_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_INIT;
      cnt     <= L_INIT;
      dcnt    <= '0;
      go_self <= 1'b0;
      use_row <= 1'b0;
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      pending <= start ? 1'b0 : (pending | tick);
      if (tick && pending && !start) begin
        overrun <= 1'b1;
      end
      if (!done) begin
        cnt <= cnt - 1'b1;
      end
      case (st)
        ST_INIT: if (done) begin
          st  <= ST_DUM_LO;
          cnt <= L_CELO;
        end
        ST_DUM_LO: if (done) begin
          st  <= ST_DUM_HI;
          cnt <= L_CEPRE;
        end
        ST_DUM_HI: if (done) begin
          if (dcnt == D_LAST) begin
            st <= ST_IDLE;
          end else begin
            dcnt <= dcnt + 1'b1;
            st   <= ST_DUM_LO;
            cnt  <= L_CELO;
          end
        end
        ST_IDLE: begin
          use_row <= ref_style;
          if (pending || tick) begin
            go_self <= 1'b0;
            st      <= ST_REQ;
          end else if (lp_req) begin
            go_self <= 1'b1;
            st      <= ST_REQ;
          end
        end
        ST_REQ: if (bus_gnt) begin
          st  <= ST_LEAD;
          cnt <= L_LEAD;
        end
        ST_LEAD: if (done) begin
          if (go_self) begin
            st  <= ST_SR_LOW;
            cnt <= L_SMIN;
          end else if (use_row == STYLE_ROW) begin
            st  <= ST_CR_LOW;
            cnt <= L_CELO;
          end else begin
            st  <= ST_AR_LOW;
            cnt <= L_ARLO;
          end
        end
        ST_AR_LOW: if (done) begin
          st  <= ST_AR_TAIL;
          cnt <= L_TAIL;
        end
        ST_AR_TAIL: if (done) st <= ST_IDLE;
        ST_CR_LOW: if (done) begin
          st  <= ST_CR_HI;
          cnt <= L_CEPRE;
        end
        ST_CR_HI: if (done) st <= ST_IDLE;
        ST_SR_LOW: if (done && !lp_req) begin
          st  <= ST_SR_EXIT;
          cnt <= L_SEXIT;
        end
        ST_SR_EXIT: if (done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign state     = st;
  assign row_inc   = (st == ST_CR_LOW) && done;
  assign timer_run = !(st inside {ST_INIT, ST_DUM_LO, ST_DUM_HI, ST_SR_LOW, ST_SR_EXIT});
endmodule

// File: rtl/psr_refresh_mgr.sv
`timescale 1ns/1ps
module psr_refresh_mgr
  import psr_pkg::*;
#(
  parameter int INIT_WAIT_CYC    = 20000,
  parameter int DUMMY_CNT        = 8,
  parameter int CE_LOW_CYC       = 12,
  parameter int CE_PRE_CYC       = 8,
  parameter int REF_INTERVAL_CYC = 3120,
  parameter int RF_LOW_CYC       = 6,
  parameter int RF_PRE_CYC       = 6,
  parameter int AUTO_CYCLE_CYC   = 20,
  parameter int CE_LEAD_CYC      = 6,
  parameter int CE_HOLD_CYC      = 4,
  parameter int SELF_MIN_CYC     = 1600,
  parameter int SELF_EXIT_CYC    = 28,
  parameter int ROW_BITS         = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lp_req,
  input  logic                ref_style,
  input  logic                bus_gnt,
  output logic                bus_req,
  output logic                ce_n,
  output logic                rfsh_n,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                init_done,
  output logic                self_active,
  output logic                overrun
);
  psr_state_e state;
  logic       tick;
  logic       timer_run;
  logic       row_inc;

  psr_tick_timer #(.INTERVAL_CYC(REF_INTERVAL_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (timer_run),
    .tick (tick)
  );

  psr_row_ctr #(.ROW_BITS(ROW_BITS)) u_row (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (row_inc),
    .row  (row_addr)
  );

  psr_fsm #(
    .INIT_WAIT_CYC (INIT_WAIT_CYC),
    .DUMMY_CNT     (DUMMY_CNT),
    .CE_LOW_CYC    (CE_LOW_CYC),
    .CE_PRE_CYC    (CE_PRE_CYC),
    .RF_LOW_CYC    (RF_LOW_CYC),
    .RF_PRE_CYC    (RF_PRE_CYC),
    .AUTO_CYCLE_CYC(AUTO_CYCLE_CYC),
    .CE_LEAD_CYC   (CE_LEAD_CYC),
    .CE_HOLD_CYC   (CE_HOLD_CYC),
    .SELF_MIN_CYC  (SELF_MIN_CYC),
    .SELF_EXIT_CYC (SELF_EXIT_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .lp_req   (lp_req),
    .ref_style(ref_style),
    .bus_gnt  (bus_gnt),
    .tick     (tick),
    .state    (state),
    .row_inc  (row_inc),
    .timer_run(timer_run),
    .overrun  (overrun)
  );

  assign bus_req     = (state != ST_IDLE);
  assign ce_n        = !(state inside {ST_DUM_LO, ST_CR_LOW});
  assign rfsh_n      = !(state inside {ST_AR_LOW, ST_SR_LOW});
  assign init_done   = !(state inside {ST_INIT, ST_DUM_LO, ST_DUM_HI});
  assign self_active = (state == ST_SR_LOW);
endmodule

// File: rtl/psr_refresh_mgr_chk.sv
`timescale 1ns/1ps
module psr_refresh_mgr_chk #(
  parameter int RF_LOW_CYC  = 6,
  parameter int CE_LEAD_CYC = 6,
  parameter int ROW_BITS    = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_gnt,
  input logic                bus_req,
  input logic                ce_n,
  input logic                rfsh_n,
  input logic [ROW_BITS-1:0] row_addr,
  input logic                init_done,
  input logic                self_active,
  input logic                overrun
);
  logic [15:0] lo_len;
  logic [15:0] ce_hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_len    <= '0;
      ce_hi_len <= '0;
    end else begin
      lo_len    <= rfsh_n ? '0 : ((lo_len == 16'hffff) ? lo_len : lo_len + 1'b1);
      ce_hi_len <= !ce_n ? '0 : ((ce_hi_len == 16'hffff) ? ce_hi_len : ce_hi_len + 1'b1);
    end
  end

  p_quiet_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> rfsh_n);

  p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_n) |-> (lo_len >= 16'(RF_LOW_CYC)));

  p_strobe_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_n) |-> (ce_hi_len >= 16'(CE_LEAD_CYC)));

  p_ce_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_n) |=> ce_n);

  p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> (row_addr == ROW_BITS'($past(row_addr) + 1'b1)));

  p_row_at_ce_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> $rose(ce_n));

  p_owned_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && (!rfsh_n || !ce_n)) |-> bus_gnt);

  p_never_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rfsh_n && !ce_n));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_exit_holds_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(self_active) |=> bus_req);
endmodule

bind psr_refresh_mgr psr_refresh_mgr_chk #(
  .RF_LOW_CYC (RF_LOW_CYC),
  .CE_LEAD_CYC(CE_LEAD_CYC),
  .ROW_BITS   (ROW_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_gnt    (bus_gnt),
  .bus_req    (bus_req),
  .ce_n       (ce_n),
  .rfsh_n     (rfsh_n),
  .row_addr   (row_addr),
  .init_done  (init_done),
  .self_active(self_active),
  .overrun    (overrun)
);

// File: tb/psr_refresh_mgr_bench.sv
`timescale 1ns/1ps
module psr_refresh_mgr_bench;
  localparam int INIT  = 20000;
  localparam int NDUM  = 8;
  localparam int CELO  = 12;
  localparam int CEPRE = 8;
  localparam int IV    = 3120;
  localparam int RFLO  = 6;
  localparam int LEAD  = 6;
  localparam int TAIL  = 14;
  localparam int SMIN  = 1600;
  localparam int SEXIT = 28;
  localparam int WD    = 150000;
  localparam int NEVER = 32'h7fffffff;

  logic clk = 1'b0;
  logic rst_n, lp_req, ref_style, bus_gnt;
  logic bus_req, ce_n, rfsh_n, init_done, self_active, overrun;
  logic [8:0] row_addr;

  always #2.5 clk = ~clk;

  psr_refresh_mgr u_psr_refresh_mgr (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .ref_style(ref_style),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .ce_n(ce_n), .rfsh_n(rfsh_n),
    .row_addr(row_addr), .init_done(init_done), .self_active(self_active),
    .overrun(overrun)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int gnt_delay = 3;

  typedef struct {bit is_rf; int width; int row; string req;} pulse_t;
  pulse_t exp_q[$];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_pulse(input bit rf, input int w, input int r, input string req);
    pulse_t p;
    p.is_rf = rf; p.width = w; p.row = r; p.req = req;
    exp_q.push_back(p);
  endtask

  task automatic pop_cmp(input bit rf, input int w, input int r);
    pulse_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R6", "unexpected pulse width", w, 0);
    end else begin
      e = exp_q.pop_front();
      check(e.is_rf == rf, e.req, "pulse pin (1=rfsh)", int'(rf), int'(e.is_rf));
      check(w == e.width, e.req, "pulse width", w, e.width);
      if (!rf) check(r == e.row, e.req, "row address", r, e.row);
    end
  endtask

  // grant responder
  initial begin
    int wcnt;
    bus_gnt = 1'b0;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (!bus_req || !init_done) begin
        bus_gnt = 1'b0;
        wcnt = 0;
      end else if (!bus_gnt) begin
        if (wcnt >= gnt_delay) bus_gnt = 1'b1;
        else wcnt++;
      end
    end
  end

  // monitor
  initial begin
    bit p_ce = 1, p_rf = 1, p_req = 1, p_gnt = 0, p_init = 0;
    bit saw_fall = 0, rf_self = 0, after_self = 0, tick_now;
    int ce_fall = 0, rf_fall = 0, ce_row = 0, rise_cyc = 0, exp_tail = 0;
    int gnt_cyc = 0, next_tick = NEVER;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        tick_now = 0;
        if (cyc == next_tick) begin
          tick_now = 1;
          next_tick += IV;
        end
        if (init_done && !p_init) begin
          check(cyc == INIT + NDUM * (CELO + CEPRE), "R2", "init_done cycle",
                cyc, INIT + NDUM * (CELO + CEPRE));
          next_tick = cyc + IV;
        end
        if (bus_gnt && !p_gnt) gnt_cyc = cyc;
        if (!ce_n && p_ce) begin
          ce_fall = cyc;
          ce_row = int'(row_addr);
          if (!saw_fall) begin
            check(cyc == INIT, "R2", "first dummy pulse cycle", cyc, INIT);
            saw_fall = 1;
          end
          if (init_done) begin
            check(bus_gnt, "R6", "ce_n low without grant", int'(bus_gnt), 1);
            check(cyc - gnt_cyc == LEAD, "R5", "row refresh lead", cyc - gnt_cyc, LEAD);
          end
        end
        if (ce_n && !p_ce) begin
          pop_cmp(1'b0, cyc - ce_fall, ce_row);
          if (init_done) begin
            rise_cyc = cyc;
            exp_tail = CEPRE;
          end
        end
        if (!rfsh_n && p_rf) begin
          rf_fall = cyc;
          rf_self = self_active;
          check(bus_gnt, "R6", "rfsh_n low without grant", int'(bus_gnt), 1);
          check(ce_n, "R8", "ce_n high at strobe fall", int'(ce_n), 1);
          check(cyc - gnt_cyc == LEAD, rf_self ? "R8" : "R4", "strobe lead",
                cyc - gnt_cyc, LEAD);
          if (rf_self) next_tick = NEVER;
        end
        if (rfsh_n && !p_rf) begin
          pop_cmp(1'b1, cyc - rf_fall, 0);
          rise_cyc = cyc;
          exp_tail = rf_self ? SEXIT : TAIL;
        end
        if (!bus_req && p_req && p_init) begin
          check(cyc - rise_cyc == exp_tail, rf_self ? "R9" : "R4", "release delay",
                cyc - rise_cyc, exp_tail);
          if (rf_self) begin
            next_tick = cyc + IV;
            after_self = 1;
            rf_self = 0;
          end
        end
        if (bus_req && !p_req && !lp_req) begin
          check(tick_now, after_self ? "R9" : "R3", "refresh request cycle",
                cyc, next_tick - IV);
          after_self = 0;
        end
        p_ce = ce_n; p_rf = rfsh_n; p_req = bus_req; p_gnt = bus_gnt; p_init = init_done;
      end
    end
  end

  task automatic wait_release();
    do @(negedge clk); while (!bus_req);
    do @(negedge clk); while (bus_req);
  endtask

  task automatic scenario();
    int f;
    for (int i = 0; i < NDUM; i++) expect_pulse(1'b0, CELO, 0, "R2");
    do @(negedge clk); while (bus_req);
    check(init_done, "R2", "init_done after dummies", int'(init_done), 1);

    expect_pulse(1'b1, RFLO, 0, "R4");
    wait_release();

    ref_style = 1'b1;
    expect_pulse(1'b0, CELO, 0, "R5");
    wait_release();
    expect_pulse(1'b0, CELO, 1, "R5");
    wait_release();
    ref_style = 1'b0;

    check(!overrun, "R7", "overrun before late grant", int'(overrun), 0);
    gnt_delay = IV + 50;
    expect_pulse(1'b1, RFLO, 0, "R4");
    wait_release();
    check(overrun, "R7", "overrun after late grant", int'(overrun), 1);
    gnt_delay = 3;

    @(negedge clk);
    lp_req = 1'b1;
    expect_pulse(1'b1, SMIN, 0, "R8");
    do @(negedge clk); while (rfsh_n);
    check(self_active, "R8", "self_active in self refresh", int'(self_active), 1);
    repeat (100) @(negedge clk);
    lp_req = 1'b0;
    do @(negedge clk); while (bus_req);
    expect_pulse(1'b1, RFLO, 0, "R9");
    wait_release();

    @(negedge clk);
    lp_req = 1'b1;
    expect_pulse(1'b1, 4000, 0, "R8");
    do @(negedge clk); while (rfsh_n);
    f = cyc;
    while (cyc < f + 3999) @(negedge clk);
    lp_req = 1'b0;
    do @(negedge clk); while (bus_req);

    expect_pulse(1'b1, RFLO, 0, "R10");
    expect_pulse(1'b1, SMIN, 0, "R10");
    do @(negedge clk); while (!bus_req);
    lp_req = 1'b1;
    do @(negedge clk); while (rfsh_n);
    check(!self_active, "R10", "refresh strobe before self refresh", int'(self_active), 0);
    do @(negedge clk); while (!rfsh_n);
    do @(negedge clk); while (rfsh_n);
    repeat (10) @(negedge clk);
    lp_req = 1'b0;
    do @(negedge clk); while (bus_req);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10", "expected pulses left", exp_q.size(), 0);
    check(overrun, "R7", "overrun still set", int'(overrun), 1);
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 0;
    rst_n = 1'b0;
    lp_req = 1'b0;
    ref_style = 1'b0;
    repeat (4) @(negedge clk);
    check(bus_req, "R1", "bus_req in reset", int'(bus_req), 1);
    check(ce_n && rfsh_n, "R1", "ce_n&rfsh_n in reset", int'(ce_n && rfsh_n), 1);
    check(!init_done && !self_active, "R1", "init_done|self_active in reset",
          int'(init_done || self_active), 0);
    check(!overrun, "R1", "overrun in reset", int'(overrun), 0);
    rst_n = 1'b1;
    fork
      scenario();
      begin
        repeat (WD) @(negedge clk);
        wd_hit = 1;
      end
    join_any
    disable fork;
    if (wd_hit) check(1'b0, "R1", "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule